// File: doc/BRIEF.md
# Notification Deferral Gate

This block sits on the side that posts completions into a queue read by a consumer running on another processor. Each time a completion is posted, it decides whether the consumer has to be nudged with a cross-processor notification. The notification only lowers latency. The consumer sweeps the queue on its own whenever it delivers an interrupt. The gate therefore withholds the notification while the consumer's most recent interrupt delivery lies within a configurable number of time ticks.

The consumer signals each interrupt delivery with a strobe. The gate then stores the current value of a free-running time counter as the last-delivery stamp. On a posted completion, the gate takes the elapsed time as a modular difference of the counter and the stamp, and compares it with the threshold register. A consumer that is not currently running cannot take a notification, so in that case the gate raises a schedule request instead. Both outputs are registered single-cycle pulses that appear one clock after the posting strobe.

Top module: `notify_gate`

## Requirements
- R1: While reset is held and just after it, `notify` and `sched_req` are 0, the threshold equals the parameter `DEF_THRESH` (default 12500 ticks, which is 100 us at a 125 MHz tick), and no delivery stamp is held.
- R2: A `post` with `running`=1 and an elapsed time strictly greater than the threshold raises `notify` for exactly the cycle after the `post` cycle.
- R3: A `post` with `running`=1 and an elapsed time less than or equal to a nonzero threshold raises neither output.
- R4: With the threshold at 0, every `post` with `running`=1 raises `notify`, including one in the same cycle as a stamp write.
- R5: A `post` with `running`=0 raises `sched_req` for exactly the cycle after the `post` cycle and never `notify`, whatever the elapsed time.
- R6: Elapsed time is `now` minus the stamp, modulo 2^TW, so a counter wrap between stamp and `post` gives the true small difference.
- R7: If `stamp_we` and `post` fall in the same cycle, the comparison uses the `now` of that cycle as the stamp (elapsed 0).
- R8: If no stamp has been written since reset, a `post` with `running`=1 raises `notify` regardless of threshold.
- R9: A threshold write (`thr_we`) applies to posts in later cycles. A `post` in the same cycle as the write is judged with the old threshold. Values up to at least 62500 ticks (500 us) are held exactly.
- R10: Without a `post` in the previous cycle, both outputs are 0, and the two outputs are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | TW | Free-running time counter |
| stamp_we | input | 1 | Consumer delivered an interrupt; capture `now` as the stamp |
| running | input | 1 | Consumer is currently executing on another processor |
| post | input | 1 | A completion was posted this cycle |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | TW | New threshold in ticks |
| notify | output | 1 | One-cycle cross-processor notification pulse |
| sched_req | output | 1 | One-cycle request to schedule the consumer |

## Verification
The posting strobe is tried at elapsed times just at and just past the threshold. This separates a strict comparison from an inclusive one. A stamp taken shortly before the counter wraps, with a post shortly after it, shows whether the subtraction is modular or a plain signed or unsigned compare. Posts in the same cycle as a stamp write, and in the same cycle as a threshold write, show which value each path uses. The cases with no stamp yet, with a zero threshold and with the consumer not running show that the gate picks the right output and never drops a needed pulse.

// File: rtl/notify_gate.sv
module notify_gate #(
  parameter int TW         = 32,
  parameter int DEF_THRESH = 12500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now,
  input  logic          stamp_we,
  input  logic          running,
  input  logic          post,
  input  logic          thr_we,
  input  logic [TW-1:0] thr_wdata,
  output logic          notify,
  output logic          sched_req
);

  localparam logic [TW-1:0] THR_RST = TW'(DEF_THRESH);

  logic [TW-1:0] stamp_q;
  logic          stamp_vld;
  logic [TW-1:0] thr_q;

  logic [TW-1:0] stamp_eff;
  logic          have_stamp;
  logic [TW-1:0] elapsed;
  logic          stale;
  logic          want_notify;
  logic          want_sched;

  assign stamp_eff   = stamp_we ? now : stamp_q;
  assign have_stamp  = stamp_we | stamp_vld;
  assign elapsed     = now - stamp_eff;
  assign stale       = !have_stamp || (thr_q == '0) || (elapsed > thr_q);
  assign want_sched  = post && !running;
  assign want_notify = post && running && stale;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_q   <= '0;
      stamp_vld <= 1'b0;
    end else if (stamp_we) begin
      stamp_q   <= now;
      stamp_vld <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      thr_q <= THR_RST;
    else if (thr_we) thr_q <= thr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notify    <= 1'b0;
      sched_req <= 1'b0;
    end else begin
      notify    <= want_notify;
      sched_req <= want_sched;
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(notify && sched_req)); // R10
  AST_NOTIFY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> $past(post && running)); // R2
  AST_SCHED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sched_req |-> $past(post && !running)); // R5
  AST_ZERO_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (post && running && thr_q == '0) |=> notify); // R4
  AST_NO_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (post && running && !stamp_vld && !stamp_we) |=> notify); // R8
  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !post |=> (!notify && !sched_req)); // R10

endmodule

// File: tb/tb_notify_gate.sv
module tb_notify_gate;
  localparam int TW = 32;
  localparam int DEF = 12500;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] now = '0;
  logic          stamp_we = 1'b0;
  logic          running = 1'b0;
  logic          post = 1'b0;
  logic          thr_we = 1'b0;
  logic [TW-1:0] thr_wdata = '0;
  logic          notify;
  logic          sched_req;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  notify_gate #(.TW(TW), .DEF_THRESH(DEF)) dut (
    .clk(clk), .rst_n(rst_n), .now(now), .stamp_we(stamp_we),
    .running(running), .post(post), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .notify(notify), .sched_req(sched_req)
  );

  task automatic check(input string req, input logic en, input logic es);
    checks++;
    if (notify !== en || sched_req !== es) begin
      fails++;
      $display("FAIL %s: notify=%b sched_req=%b expected notify=%b sched_req=%b",
               req, notify, sched_req, en, es);
    end
  endtask

  task automatic step(input logic [TW-1:0] t, input logic sw, input logic run,
                      input logic p, input logic tw, input logic [TW-1:0] tv);
    now = t; stamp_we = sw; running = run; post = p; thr_we = tw; thr_wdata = tv;
    @(posedge clk); #1;
    stamp_we = 0; post = 0; thr_we = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 0, 0);
    rst_n = 1;
  endtask

  task automatic t_no_stamp();
    step(32'd5, 0, 1, 1, 0, 0);
    check("R8 no stamp", 1, 0);
    step(32'd6, 0, 1, 0, 0, 0);
    check("R10 pulse ends", 0, 0);
  endtask

  task automatic t_threshold_edge();
    step(32'd1000, 1, 1, 0, 0, 0);
    check("R1 default thr idle", 0, 0);
    step(32'd1000 + DEF, 0, 1, 1, 0, 0);
    check("R3 equal withheld", 0, 0);
    step(32'd1000 + DEF + 1, 0, 1, 1, 0, 0);
    check("R2 past threshold", 1, 0);
  endtask

  task automatic t_not_running();
    step(32'd1000 + 99999, 0, 0, 1, 0, 0);
    check("R5 sched stale", 0, 1);
    step(32'd1001, 0, 0, 1, 0, 0);
    check("R5 sched recent", 0, 1);
  endtask

  task automatic t_wrap();
    step(32'hFFFF_FF9C, 1, 1, 0, 0, 0);
    step(32'd50, 0, 1, 1, 0, 0);
    check("R6 wrap small", 0, 0);
    step(32'd12401, 0, 1, 1, 0, 0);
    check("R6 wrap large", 1, 0);
  endtask

  task automatic t_same_cycle_stamp();
    step(32'd900000, 1, 1, 1, 0, 0);
    check("R7 fresh stamp", 0, 0);
  endtask

  task automatic t_zero_and_write();
    step(32'd900001, 0, 1, 0, 1, 32'd0);
    step(32'd900002, 1, 1, 1, 0, 0);
    check("R4 zero thr", 1, 0);
    step(32'd900500, 0, 1, 1, 1, 32'd1000);
    check("R9 old thr used", 1, 0);
    step(32'd900600, 0, 1, 1, 0, 0);
    check("R9 new thr", 0, 0);
    step(32'd900610, 0, 1, 0, 1, 32'd62500);
    step(32'd900002 + 62500, 0, 1, 1, 0, 0);
    check("R9 500us hold", 0, 0);
    step(32'd900002 + 62501, 0, 1, 1, 0, 0);
    check("R9 500us past", 1, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_no_stamp();
        t_threshold_edge();
        t_not_running();
        t_wrap();
        t_same_cycle_stamp();
        t_zero_and_write();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: expired expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule